// File: doc/BRIEF.md
# LCD Pixel Unpacker with Palette

This block sits between a frame-buffer fetch engine and a display pipeline. It takes 32-bit frame-buffer words over a valid/ready input channel and breaks each word into one or more pixels. Each pixel leaves as 24-bit RGB over a valid/ready output channel. A three-bit depth code selects the pixel size, from 1 bit to 32 bits. Two ordering bits pick where in the word each pixel lives. A colour-swap bit and an external two-bit selector for the 16-bit format shape the colour conversion.

Depths of 8 bits and below index a 256-entry palette. The palette is held as 128 words of 32 bits, two 16-bit entries per word, and is written and read over a plain register port. Wider depths are direct colour and bypass the palette. The mode is captured when a word is accepted, so reconfiguring during a word does not disturb it. A separate combinational output gives the number of frame-buffer bytes that one display line of a given width occupies at the current depth.

Top module: `lcdpx_unpack`

## Requirements
- R1: Depth codes are 0=1 bpp, 1=2 bpp, 2=4 bpp, 3=8 bpp, 4=16 bpp (5551), 5=32 bpp, 6=16 bpp (565), 7=12 bpp held in a 16-bit container. Each accepted word yields 32 divided by the container width pixels (32, 16, 8, 4, 2, 1, 2, 2).
- R2: `line_bytes` equals `line_width` shifted right by 3, 2 or 1 for codes 0, 1 and 2. It equals `line_width` for code 3, twice `line_width` for codes 4, 6 and 7, and four times `line_width` for code 5.
- R3: A register write with `reg_addr` in 0x200..0x3FC stores `reg_wdata` in palette word (`reg_addr`-0x200)/4. A read at such an address returns the raw stored word. Writes outside that range leave the palette unchanged, and reads outside it return 0.
- R4: For codes 0-3 the pixel value is a palette entry index. Entry 2n is bits [15:0] of palette word n and entry 2n+1 is bits [31:16]. In an entry, red is [4:0], green is [9:5] and blue is [14:10], each widened to 8 bits by appending three zeros. Bit 15 is ignored, and no red/blue swap applies.
- R5: Direct colour, with `px_rgb` = {R,G,B} and R in [23:16]. For 32 bpp, R=[7:0], G=[15:8] and B=[23:16]. For 12 bpp, R=[3:0], G=[7:4] and B=[11:8], each followed by four zeros. For 565, R=[4:0]<<3, G=[10:5]<<2 and B=[15:11]<<3. For 5551, R=[4:0]<<3, G=[9:5]<<3 and B=[14:10]<<3, and bit 15 is ignored.
- R6: For code 4, `fmt16_sel`=1 decodes 5551 and `fmt16_sel`=3 decodes 565 with red and blue always swapped. `fmt16_sel`=0 or 2 decodes 565 and follows `cfg_bgr`. Code 6 always decodes 565.
- R7: In direct-colour modes, `cfg_bgr`=1 exchanges the R and B output bytes.
- R8: With both ordering bits clear, pixel k of a word starts at bit k times the container width.
- R9: With `cfg_be_byte`=1, pixel k starts at bit 32-(k+1) times the container width, so pixel 0 is the most significant. `cfg_be_pix` is then ignored.
- R10: With only `cfg_be_pix`=1 and a container below 8 bits, bytes are taken from least to most significant, and pixels within a byte from its most significant end. For containers of 8 bits or more the order is as in R8.
- R11: Pixels leave in order, and `in_ready` stays low until the last pixel of the held word is accepted. A pixel stalled by `px_ready`=0 stays unchanged while no palette write occurs.
- R12: After reset, `px_valid` is 0, `in_ready` is 1 and every palette word reads 0.
- R13: Depth, ordering, swap and 16-bit select are captured when a word is accepted. Changing them while the word drains has no effect on its pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_depth | input | 3 | Pixel depth code |
| cfg_be_byte | input | 1 | Big-endian byte ordering |
| cfg_be_pix | input | 1 | Big-endian pixel ordering within a byte |
| cfg_bgr | input | 1 | Red/blue swap for direct colour |
| fmt16_sel | input | 2 | External 16-bpp format select |
| line_width | input | 12 | Line width in pixels |
| line_bytes | output | 14 | Bytes per line at the current depth |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word ready |
| in_word | input | 32 | Frame-buffer word |
| px_valid | output | 1 | Pixel valid |
| px_ready | input | 1 | Pixel ready |
| px_rgb | output | 24 | Pixel colour {R,G,B} |

## Verification
The bench builds the block with its defaults: a 128-word palette at 0x200, a 12-bit address and a 12-bit line width. These cover every palette entry reachable by 8-bit indices, both ends of the register window, and the largest shift in the bytes-per-line output. With 32 pixels per word at 1 bpp and a single pixel at 32 bpp, the random back-pressure reaches both the longest and the shortest drain. Every pairing of ordering bits, swap bit and 16-bit select is also reached.

// File: rtl/lcdpx_pkg.sv
package lcdpx_pkg;

    typedef enum logic [2:0] {
        DEP_1   = 3'd0,
        DEP_2   = 3'd1,
        DEP_4   = 3'd2,
        DEP_8   = 3'd3,
        DEP_16A = 3'd4,
        DEP_32  = 3'd5,
        DEP_16B = 3'd6,
        DEP_12  = 3'd7
    } depth_e;

    typedef struct packed {
        depth_e     depth;
        logic       be_byte;
        logic       be_pix;
        logic       bgr;
        logic [1:0] sel16;
    } mode_t;

    // log2 of the bit container one pixel occupies in a word
    function automatic logic [2:0] cont_log2(input depth_e d);
        case (d)
            DEP_1:   return 3'd0;
            DEP_2:   return 3'd1;
            DEP_4:   return 3'd2;
            DEP_8:   return 3'd3;
            DEP_32:  return 3'd5;
            default: return 3'd4;
        endcase
    endfunction

    // index of the final pixel in one word
    function automatic logic [4:0] last_index(input depth_e d);
        return 5'((32 >> cont_log2(d)) - 1);
    endfunction

endpackage

// File: rtl/lcdpx_palette.sv
module lcdpx_palette
    import lcdpx_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int WORDS  = 128,
    parameter logic [ADDR_W-1:0] BASE = 12'h200
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [31:0]            wdata,
    output logic [31:0]            rdata,
    input  logic [$clog2(WORDS):0] entry_idx,
    output logic [15:0]            entry
);
    localparam int WI_W = $clog2(WORDS);
    localparam int SPAN = WORDS * 4;

    logic [31:0]       mem_q [WORDS];
    logic [31:0]       mem_d [WORDS];
    logic [ADDR_W-1:0] rel;
    logic              hit;
    logic [WI_W-1:0]   widx;
    logic [31:0]       pair;
    logic              unused_low;

    assign rel        = addr - BASE;
    assign hit        = (addr >= BASE) && (rel < ADDR_W'(SPAN));
    assign widx       = rel[WI_W+1:2];
    assign unused_low = ^rel[1:0];

    always_comb begin
        for (int i = 0; i < WORDS; i++) mem_d[i] = mem_q[i];
        if (wr_en && hit) mem_d[widx] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rdata = hit ? mem_q[widx] : 32'd0;
    assign pair  = mem_q[entry_idx[WI_W:1]];
    assign entry = entry_idx[0] ? pair[31:16] : pair[15:0];

    // R3: a stored word is read back unchanged at the same address
    a_r3_readback: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en && hit) && addr == $past(addr)) |-> rdata == $past(wdata));

    // R3: out-of-window reads return zero
    a_r3_outside_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr < BASE) |-> rdata == 32'd0);

endmodule

// File: rtl/lcdpx_extract.sv
module lcdpx_extract
    import lcdpx_pkg::*;
(
    input  logic [31:0] word,
    input  mode_t       mode,
    input  logic [4:0]  idx,
    output logic [31:0] field
);
    int          l_i;
    int          k_i;
    int          cw_i;
    int          off_i;
    logic [31:0] shifted;

    always_comb begin
        l_i  = int'(cont_log2(mode.depth));
        k_i  = int'(idx);
        cw_i = 1 << l_i;
        if (mode.be_byte) begin
            off_i = 32 - (k_i + 1) * cw_i;
        end else if (mode.be_pix && l_i < 3) begin
            off_i = (k_i >> (3 - l_i)) * 8 + 8
                  - ((k_i & ((1 << (3 - l_i)) - 1)) + 1) * cw_i;
        end else begin
            off_i = k_i * cw_i;
        end
        shifted = word >> off_i[4:0];
        field   = (cw_i == 32) ? shifted
                               : shifted & ((32'd1 << cw_i) - 32'd1);
    end

endmodule

// File: rtl/lcdpx_color.sv
module lcdpx_color
    import lcdpx_pkg::*;
(
    input  mode_t       mode,
    input  logic [31:0] field,
    input  logic [15:0] pal_entry,
    output logic [23:0] rgb
);
    logic [7:0] r, g, b;
    logic       swap;
    logic       unused_hi;

    assign unused_hi = ^{field[31:24], pal_entry[15]};

    always_comb begin
        swap = mode.bgr;
        case (mode.depth)
            DEP_1, DEP_2, DEP_4, DEP_8: begin
                r    = {pal_entry[4:0],   3'b000};
                g    = {pal_entry[9:5],   3'b000};
                b    = {pal_entry[14:10], 3'b000};
                swap = 1'b0;
            end
            DEP_32: begin
                r = field[7:0];
                g = field[15:8];
                b = field[23:16];
            end
            DEP_12: begin
                r = {field[3:0],  4'h0};
                g = {field[7:4],  4'h0};
                b = {field[11:8], 4'h0};
            end
            DEP_16A: begin
                if (mode.sel16 == 2'd1) begin
                    r = {field[4:0],   3'b000};
                    g = {field[9:5],   3'b000};
                    b = {field[14:10], 3'b000};
                end else begin
                    r = {field[4:0],   3'b000};
                    g = {field[10:5],  2'b00};
                    b = {field[15:11], 3'b000};
                    if (mode.sel16 == 2'd3) swap = 1'b1;
                end
            end
            default: begin
                r = {field[4:0],   3'b000};
                g = {field[10:5],  2'b00};
                b = {field[15:11], 3'b000};
            end
        endcase
        rgb = swap ? {b, g, r} : {r, g, b};
    end

endmodule

// File: rtl/lcdpx_unpack.sv
module lcdpx_unpack
    import lcdpx_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int PAL_WORDS = 128,
    parameter int WIDTH_W   = 12,
    parameter logic [ADDR_W-1:0] PAL_BASE = 12'h200
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           cfg_depth,
    input  logic                 cfg_be_byte,
    input  logic                 cfg_be_pix,
    input  logic                 cfg_bgr,
    input  logic [1:0]           fmt16_sel,
    input  logic [WIDTH_W-1:0]   line_width,
    output logic [WIDTH_W+1:0]   line_bytes,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [31:0]          in_word,
    output logic                 px_valid,
    input  logic                 px_ready,
    output logic [23:0]          px_rgb
);
    localparam int LB_W = WIDTH_W + 2;
    localparam int EI_W = $clog2(PAL_WORDS) + 1;

    typedef struct packed {
        logic [31:0] word;
        mode_t       mode;
        logic [4:0]  cnt;
        logic        busy;
    } state_t;

    state_t      st_d, st_q;
    mode_t       cfg_mode;
    logic [31:0] field;
    logic [15:0] pal_entry;
    logic        px_fire;
    logic        at_last;
    logic [LB_W-1:0] wid_ext;
    logic        unused_field;

    assign cfg_mode = '{depth: depth_e'(cfg_depth), be_byte: cfg_be_byte,
                        be_pix: cfg_be_pix, bgr: cfg_bgr, sel16: fmt16_sel};

    assign px_valid = st_q.busy;
    assign px_fire  = st_q.busy && px_ready;
    assign at_last  = st_q.cnt == last_index(st_q.mode.depth);
    assign in_ready = !st_q.busy || (px_fire && at_last);

    always_comb begin
        st_d = st_q;
        if (px_fire) begin
            if (at_last) st_d.busy = 1'b0;
            else         st_d.cnt  = st_q.cnt + 5'd1;
        end
        if (in_valid && in_ready) begin
            st_d.word = in_word;
            st_d.mode = cfg_mode;
            st_d.cnt  = '0;
            st_d.busy = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{word: '0, mode: '{depth: DEP_1, default: '0},
                              cnt: '0, busy: 1'b0};
        else        st_q <= st_d;
    end

    lcdpx_extract u_extract (
        .word  (st_q.word),
        .mode  (st_q.mode),
        .idx   (st_q.cnt),
        .field (field)
    );

    assign unused_field = ^field[31:EI_W];

    lcdpx_palette #(
        .ADDR_W (ADDR_W),
        .WORDS  (PAL_WORDS),
        .BASE   (PAL_BASE)
    ) u_palette (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_we),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .entry_idx (field[EI_W-1:0]),
        .entry     (pal_entry)
    );

    lcdpx_color u_color (
        .mode      (st_q.mode),
        .field     (field),
        .pal_entry (pal_entry),
        .rgb       (px_rgb)
    );

    // R2: bytes per line from the live depth code
    assign wid_ext = LB_W'(line_width);
    always_comb begin
        case (depth_e'(cfg_depth))
            DEP_1:   line_bytes = wid_ext >> 3;
            DEP_2:   line_bytes = wid_ext >> 2;
            DEP_4:   line_bytes = wid_ext >> 1;
            DEP_8:   line_bytes = wid_ext;
            DEP_32:  line_bytes = wid_ext << 2;
            default: line_bytes = wid_ext << 1;
        endcase
    end

    // R11: a stalled pixel holds while the palette is not rewritten
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (px_valid && !px_ready && !reg_we) |=> (px_valid && $stable(px_rgb)));

    // R11: an accepted word produces a pixel on the next cycle
    a_r11_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> px_valid);

    // R4: palette colours always carry three zero low bits per channel
    a_r4_pal_low: assert property (@(posedge clk) disable iff (!rst_n)
        (px_valid && st_q.mode.depth <= DEP_8) |->
        (px_rgb[2:0] == 3'b0 && px_rgb[10:8] == 3'b0 && px_rgb[18:16] == 3'b0));

    // R2: at 8 bpp a line takes exactly one byte per pixel
    a_r2_bytes8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_depth == 3'd3) |-> line_bytes == LB_W'(line_width));

endmodule

// File: tb/lcdpx_unpack_bench.sv
module lcdpx_unpack_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_depth = 3'd0;
    logic        cfg_be_byte = 1'b0, cfg_be_pix = 1'b0, cfg_bgr = 1'b0;
    logic [1:0]  fmt16_sel = 2'd0;
    logic [11:0] line_width = 12'd0;
    logic [13:0] line_bytes;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = 12'd0;
    logic [31:0] reg_wdata = 32'd0, reg_rdata;
    logic        in_valid = 1'b0, in_ready;
    logic [31:0] in_word = 32'd0;
    logic        px_valid, px_ready = 1'b0;
    logic [23:0] px_rgb;

    int checks = 0;
    int fails  = 0;
    logic [31:0] pal_m [128];

    always #(CLK_PERIOD/2) clk = ~clk;

    lcdpx_unpack u_lcdpx_unpack (
        .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .cfg_be_byte(cfg_be_byte),
        .cfg_be_pix(cfg_be_pix), .cfg_bgr(cfg_bgr), .fmt16_sel(fmt16_sel),
        .line_width(line_width), .line_bytes(line_bytes), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
        .px_valid(px_valid), .px_ready(px_ready), .px_rgb(px_rgb)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int cw_of(input logic [2:0] d);
        case (d)
            3'd0: return 1;
            3'd1: return 2;
            3'd2: return 4;
            3'd3: return 8;
            3'd5: return 32;
            default: return 16;
        endcase
    endfunction

    function automatic int bit_off(input logic [2:0] d, input bit bb, input bit bp,
                                   input int k);
        int cw = cw_of(d);
        if (bb) return 32 - (k + 1) * cw;
        if (bp && cw < 8) return ((k * cw) / 8) * 8 + 8 - ((k * cw) % 8) - cw;
        return k * cw;
    endfunction

    function automatic logic [23:0] exp_px(input logic [31:0] w, input logic [2:0] d,
                                           input bit bb, input bit bp, input bit bgr,
                                           input logic [1:0] sel, input int k);
        logic [63:0] m;
        logic [31:0] f;
        logic [15:0] e;
        logic [7:0]  r, g, b;
        bit          sw;
        m  = (64'd1 << cw_of(d)) - 64'd1;
        f  = (w >> bit_off(d, bb, bp, k)) & m[31:0];
        sw = bgr;
        if (d <= 3'd3) begin
            e  = f[0] ? pal_m[f[7:1]][31:16] : pal_m[f[7:1]][15:0];
            r  = {e[4:0], 3'b0}; g = {e[9:5], 3'b0}; b = {e[14:10], 3'b0};
            sw = 1'b0;
        end else if (d == 3'd5) begin
            r = f[7:0]; g = f[15:8]; b = f[23:16];
        end else if (d == 3'd7) begin
            r = {f[3:0], 4'h0}; g = {f[7:4], 4'h0}; b = {f[11:8], 4'h0};
        end else if (d == 3'd4 && sel == 2'd1) begin
            r = {f[4:0], 3'b0}; g = {f[9:5], 3'b0}; b = {f[14:10], 3'b0};
        end else begin
            r = {f[4:0], 3'b0}; g = {f[10:5], 2'b0}; b = {f[15:11], 3'b0};
            if (d == 3'd4 && sel == 2'd3) sw = 1'b1;
        end
        return sw ? {b, g, r} : {r, g, b};
    endfunction

    function automatic logic [13:0] exp_lb(input logic [2:0] d, input logic [11:0] w);
        case (d)
            3'd0: return 14'(w / 8);
            3'd1: return 14'(w / 4);
            3'd2: return 14'(w / 2);
            3'd3: return 14'(w);
            3'd5: return 14'(w) * 14'd4;
            default: return 14'(w) * 14'd2;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] d, input bit bb, input bit bp);
        string s;
        s = (d <= 3'd3) ? "R1 R4" : (d == 3'd4 ? "R1 R5 R6 R7" : "R1 R5 R7");
        if (bb) s = {s, " R9"};
        else if (bp) s = {s, " R10"};
        else s = {s, " R8"};
        return {s, " R11 R13"};
    endfunction

    task automatic pal_write(input logic [11:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        if (a >= 12'h200 && a < 12'h400) pal_m[a[8:2]] = v;
    endtask

    task automatic pal_read(input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(reg_rdata == exp, "R3 palette read", reg_rdata, exp);
    endtask

    task automatic run_word(input logic [31:0] w, input bit scramble);
        logic [2:0] d   = cfg_depth;
        bit         bb  = cfg_be_byte, bp = cfg_be_pix, bgr = cfg_bgr;
        logic [1:0] sel = fmt16_sel;
        int         n   = 32 / cw_of(d);
        int         k   = 0;
        logic [23:0] e;
        @(negedge clk);
        in_word = w; in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        if (scramble) begin
            cfg_depth = 3'($urandom); cfg_be_byte = 1'($urandom);
            cfg_be_pix = 1'($urandom); cfg_bgr = 1'($urandom);
            fmt16_sel = 2'($urandom);
        end
        while (k < n) begin
            px_ready = ($urandom % 4) != 0;
            #1;
            e = exp_px(w, d, bb, bp, bgr, sel, k);
            check(px_valid && px_rgb == e, tag_of(d, bb, bp), {7'd0, px_valid, px_rgb},
                  {8'd1, e});
            if (k < n - 1)
                check(!in_ready, "R11 input stalled mid-word", {31'd0, in_ready}, 32'd0);
            if (px_ready) k++;
            @(negedge clk);
        end
        px_ready = 1'b0;
    endtask

    task automatic set_mode(input logic [2:0] d, input bit bb, input bit bp,
                            input bit bgr, input logic [1:0] sel);
        cfg_depth = d; cfg_be_byte = bb; cfg_be_pix = bp; cfg_bgr = bgr; fmt16_sel = sel;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 128; i++) pal_m[i] = 32'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R12: reset state
        check(!px_valid, "R12 px_valid after reset", {31'd0, px_valid}, 32'd0);
        check(in_ready, "R12 in_ready after reset", {31'd0, in_ready}, 32'd1);
        pal_read(12'h200, 32'd0);
        pal_read(12'h3FC, 32'd0);

        // R2: bytes per line for every depth and several widths
        for (int d = 0; d < 8; d++) begin
            foreach (line_width[i]) begin end
            for (int j = 0; j < 3; j++) begin
                @(negedge clk);
                cfg_depth  = 3'(d);
                line_width = (j == 0) ? 12'd640 : (j == 1) ? 12'd13 : 12'hFFF;
                #1;
                check(line_bytes == exp_lb(3'(d), line_width), "R2 line bytes",
                      {18'd0, line_bytes}, {18'd0, exp_lb(3'(d), line_width)});
            end
        end

        // R3: fill palette, read back, out-of-window accesses
        for (int i = 0; i < 128; i++) pal_write(12'(12'h200 + i * 4), $urandom);
        pal_read(12'h200, pal_m[0]);
        pal_read(12'h27C, pal_m[31]);
        pal_read(12'h3FC, pal_m[127]);
        pal_write(12'h1FC, 32'hDEAD_BEEF);
        pal_write(12'h400, 32'hCAFE_F00D);
        pal_read(12'h1FC, 32'd0);
        pal_read(12'h400, 32'd0);
        pal_read(12'h200, pal_m[0]);
        pal_read(12'h3FC, pal_m[127]);

        // Directed: each depth with every ordering, and the 16-bpp selects
        for (int d = 0; d < 8; d++)
            for (int o = 0; o < 4; o++) begin
                set_mode(3'(d), o[1], o[0], 1'b0, 2'd1);
                run_word(32'h1234_5678, 1'b0);
                run_word(32'h8000_0001, 1'b0);
            end
        for (int s = 0; s < 4; s++)
            for (int c = 0; c < 2; c++) begin
                set_mode(3'd4, 1'b0, 1'b0, c[0], 2'(s));
                run_word(32'hF81F_07E0, 1'b0);
                set_mode(3'd6, 1'b0, 1'b0, c[0], 2'(s));
                run_word(32'hF81F_07E0, 1'b0);
                set_mode(3'd5, 1'b0, 1'b0, c[0], 2'(s));
                run_word(32'h00A5_3C0F, 1'b0);
            end

        // Random words, random modes, mode changed while draining (R13)
        for (int i = 0; i < 300; i++) begin
            set_mode(3'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom));
            run_word($urandom, 1'b1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule